// File: doc/BRIEF.md
# Isochronous Transmit Endpoint Packet Buffer

This block holds the outgoing packets of one device endpoint that sends data to the host. A local loader, either a processor or a DMA engine, writes bytes into a small packet store and marks each packet complete with a commit strobe. The block keeps one complete packet, or two when double buffering is selected. Packets leave in the order they were committed. When the bus side reports an IN token, the block answers one cycle later. It either offers the oldest complete packet with its byte length, or it handles the case where nothing is ready.

With isochronous protocol selected, a token that finds no complete packet gets a zero-length packet. It also sets a sticky underrun flag, which software can inspect after every packet. In the other protocols such a token gets a NAK, a packet is freed only when it is acknowledged, and a data-toggle bit is tracked. A DMA request stays high while a packet slot is free. The endpoint interrupt pulses on each freed packet, unless DMA mode suppresses it. An underrun always pulses the interrupt. A direction control must select transmit before the store accepts data or tokens, because the store may be shared with a receive endpoint. A flush empties the store.

Top module: `iso_tx_pktbuf`

## Requirements
- R1: With cfg_dbl low at most one committed packet is held, with it high at most two. Byte writes and commit strobes that arrive while the store is full are ignored. pkt_count reports the number of committed packets not yet freed.
- R2: dma_req is high exactly when cfg_dma_en and cfg_tx_dir are high and pkt_count is below the capacity given in R1.
- R3: A packet keeps only its first min(cfg_maxp, MAX_BYTES) bytes, and further writes to it are dropped. tx_len reports the kept length. Shorter packets, including zero-length ones, are sent at their own length.
- R4: Packets are sent oldest first. rd_data presents the bytes of the packet being sent in write order, and each rd_en pulse advances by one byte.
- R5: With cfg_iso high, an in_tok that finds pkt_count zero gives tx_go with tx_len 0 in the next cycle and sets underrun. underrun stays set until uf_clr or flush. With cfg_iso low the same token gives a tx_nak pulse instead and leaves underrun unchanged.
- R6: irq is a one-cycle pulse in the cycle after a packet is freed, when cfg_int_en is high and cfg_dma_en and cfg_dma_mode are not both high. In the cycle of an underrun's tx_go, irq pulses whenever cfg_int_en is high.
- R7: With cfg_iso high, every tx_done frees the packet, tx_data1 reads 0, and cfg_force_tog and tx_ack have no effect. With cfg_iso low, tx_done with tx_ack frees the packet and flips the toggle. tx_done without tx_ack keeps the packet for a resend from its first byte, and flips the toggle only when cfg_force_tog is high.
- R8: With cfg_tx_dir low, writes, commits and in_tok are ignored: no tx_go, no tx_nak, pkt_count unchanged, dma_req low.
- R9: flush discards all committed and partly written packets, sets pkt_count to 0 and clears underrun in the next cycle.
- R10: After reset pkt_count is 0, and underrun, irq, tx_go, tx_nak and tx_data1 are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_iso | input | 1 | Select isochronous protocol |
| cfg_dbl | input | 1 | Enable double packet buffering |
| cfg_dma_en | input | 1 | Enable DMA requests |
| cfg_dma_mode | input | 1 | Suppress completion interrupts when DMA is enabled |
| cfg_tx_dir | input | 1 | Select transmit direction for the store |
| cfg_force_tog | input | 1 | Flip the toggle on unacknowledged sends (non-isochronous) |
| cfg_int_en | input | 1 | Endpoint interrupt enable |
| cfg_maxp | input | LEN_W | Maximum packet size in bytes |
| flush | input | 1 | Discard all buffered packets |
| uf_clr | input | 1 | Clear the underrun flag |
| ld_wr | input | 1 | Loader byte write strobe |
| ld_data | input | DATA_W | Loader byte |
| ld_commit | input | 1 | Mark the packet being loaded complete |
| dma_req | output | 1 | A packet slot is free |
| in_tok | input | 1 | IN token pulse from the bus side |
| tx_go | output | 1 | Answer pulse: a packet (possibly zero length) is offered |
| tx_len | output | LEN_W | Length of the offered packet |
| tx_data1 | output | 1 | Data toggle for the offered packet |
| tx_nak | output | 1 | Answer pulse: nothing to send (non-isochronous) |
| rd_en | input | 1 | Bus side consumes one byte |
| rd_data | output | DATA_W | Current byte of the packet being sent |
| tx_done | input | 1 | Bus side finished sending the offered packet |
| tx_ack | input | 1 | Host acknowledged the packet (with tx_done) |
| underrun | output | 1 | Sticky underrun flag |
| irq | output | 1 | Endpoint interrupt pulse |
| pkt_count | output | 2 | Committed packets held |

## Verification
The assertions assume that the bus side behaves like a real transmitter. It raises tx_done only after its own in_tok has been answered with tx_go. It never pulses rd_en beyond tx_len. It sends no new token while a packet is in flight. Configuration is changed only between transactions. The bench keeps to these rules by driving all bus traffic through one task that issues a token, reads exactly the offered length and then reports completion, and by changing configuration only while the endpoint is idle.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
    // Sender state of the bus-facing side.
    typedef enum logic [1:0] {
        SND_IDLE = 2'd0,
        SND_DATA = 2'd1,
        SND_ZLP  = 2'd2
    } snd_e;
endpackage

// File: rtl/iso_tx_store.sv
// Packet byte store: two slots of MAX_BYTES each, addressed {slot, offset}.
module iso_tx_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/iso_tx_ctrl.sv
// Slot accounting, token answering, underrun, toggle and interrupt logic.
module iso_tx_ctrl
    import iso_tx_pkg::*;
#(
    parameter  int MAX_BYTES = 64,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int PTR_W     = $clog2(MAX_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_iso,
    input  logic             cfg_dbl,
    input  logic             cfg_dma_en,
    input  logic             cfg_dma_mode,
    input  logic             cfg_tx_dir,
    input  logic             cfg_force_tog,
    input  logic             cfg_int_en,
    input  logic [LEN_W-1:0] cfg_maxp,
    input  logic             flush,
    input  logic             uf_clr,
    input  logic             ld_wr,
    input  logic             ld_commit,
    input  logic             in_tok,
    input  logic             rd_en,
    input  logic             tx_done,
    input  logic             tx_ack,
    output logic             wr_en,
    output logic [PTR_W:0]   wr_addr,
    output logic [PTR_W:0]   rd_addr,
    output logic             dma_req,
    output logic             tx_go,
    output logic [LEN_W-1:0] tx_len,
    output logic             tx_data1,
    output logic             tx_nak,
    output logic             underrun,
    output logic             irq,
    output logic [1:0]       pkt_count
);
    typedef struct packed {
        logic [1:0]       count;
        logic             wr_slot;
        logic             rd_slot;
        logic [LEN_W-1:0] wr_cnt;
        logic [LEN_W-1:0] len0;
        logic [LEN_W-1:0] len1;
        logic [LEN_W-1:0] rd_ptr;
        snd_e             snd;
        logic             go;
        logic             nak;
        logic [LEN_W-1:0] len_out;
        logic             irq;
        logic             uf;
        logic             tog;
    } st_t;

    localparam st_t ST_RESET = '{
        count: 2'd0, wr_slot: 1'b0, rd_slot: 1'b0, wr_cnt: '0,
        len0: '0, len1: '0, rd_ptr: '0, snd: SND_IDLE, go: 1'b0,
        nak: 1'b0, len_out: '0, irq: 1'b0, uf: 1'b0, tog: 1'b0
    };

    st_t st_d, st_q;

    logic [1:0]       cap;
    logic             room;
    logic [LEN_W-1:0] lim;
    logic             wr_ok;
    logic             commit;
    logic             freed;
    logic             cmpl_irq_ok;

    assign cap         = cfg_dbl ? 2'd2 : 2'd1;
    assign room        = st_q.count < cap;
    assign lim         = (cfg_maxp > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : cfg_maxp;
    assign wr_ok       = cfg_tx_dir && ld_wr && room && (st_q.wr_cnt < lim) && !flush;
    assign commit      = cfg_tx_dir && ld_commit && room;
    assign cmpl_irq_ok = cfg_int_en && !(cfg_dma_en && cfg_dma_mode);

    always_comb begin
        st_d     = st_q;
        st_d.go  = 1'b0;
        st_d.nak = 1'b0;
        st_d.irq = 1'b0;
        freed    = 1'b0;

        // Loader side
        if (wr_ok) st_d.wr_cnt = st_q.wr_cnt + 1'b1;
        if (commit) begin
            if (st_q.wr_slot) st_d.len1 = st_d.wr_cnt;
            else              st_d.len0 = st_d.wr_cnt;
            st_d.wr_slot = ~st_q.wr_slot;
            st_d.wr_cnt  = '0;
        end

        // Byte consumption
        if (rd_en && st_q.snd == SND_DATA) st_d.rd_ptr = st_q.rd_ptr + 1'b1;

        // Completion report from the bus side
        if (tx_done) begin
            case (st_q.snd)
                SND_DATA: begin
                    if (cfg_iso || tx_ack) begin
                        freed        = 1'b1;
                        st_d.rd_slot = ~st_q.rd_slot;
                        if (!cfg_iso) st_d.tog = ~st_q.tog;
                        if (cmpl_irq_ok) st_d.irq = 1'b1;
                    end else if (cfg_force_tog) begin
                        st_d.tog = ~st_q.tog;
                    end
                    st_d.rd_ptr = '0;
                    st_d.snd    = SND_IDLE;
                end
                SND_ZLP:  st_d.snd = SND_IDLE;
                default:  ;
            endcase
        end

        if (uf_clr) st_d.uf = 1'b0;

        // Token answer
        if (in_tok && cfg_tx_dir && st_q.snd == SND_IDLE) begin
            if (st_q.count != 2'd0) begin
                st_d.go      = 1'b1;
                st_d.len_out = st_q.rd_slot ? st_q.len1 : st_q.len0;
                st_d.snd     = SND_DATA;
                st_d.rd_ptr  = '0;
            end else if (cfg_iso) begin
                st_d.go      = 1'b1;
                st_d.len_out = '0;
                st_d.snd     = SND_ZLP;
                st_d.uf      = 1'b1;
                st_d.irq     = cfg_int_en;
            end else begin
                st_d.nak     = 1'b1;
            end
        end

        case ({commit, freed})
            2'b10:   st_d.count = st_q.count + 2'd1;
            2'b01:   st_d.count = st_q.count - 2'd1;
            default: st_d.count = st_q.count;
        endcase

        if (flush) begin
            st_d.count   = 2'd0;
            st_d.wr_slot = 1'b0;
            st_d.rd_slot = 1'b0;
            st_d.wr_cnt  = '0;
            st_d.rd_ptr  = '0;
            st_d.snd     = SND_IDLE;
            st_d.uf      = 1'b0;
            st_d.go      = 1'b0;
            st_d.nak     = 1'b0;
            st_d.irq     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign wr_en     = wr_ok;
    assign wr_addr   = {st_q.wr_slot, st_q.wr_cnt[PTR_W-1:0]};
    assign rd_addr   = {st_q.rd_slot, st_q.rd_ptr[PTR_W-1:0]};
    assign dma_req   = cfg_dma_en && cfg_tx_dir && room;
    assign tx_go     = st_q.go;
    assign tx_len    = st_q.len_out;
    assign tx_data1  = !cfg_iso && st_q.tog;
    assign tx_nak    = st_q.nak;
    assign underrun  = st_q.uf;
    assign irq       = st_q.irq;
    assign pkt_count = st_q.count;
endmodule

// File: rtl/iso_tx_pktbuf.sv
// Transmit packet buffer for one IN endpoint. MAX_BYTES must be a power of two.
module iso_tx_pktbuf #(
    parameter  int DATA_W    = 8,
    parameter  int MAX_BYTES = 64,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int PTR_W     = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_iso,
    input  logic              cfg_dbl,
    input  logic              cfg_dma_en,
    input  logic              cfg_dma_mode,
    input  logic              cfg_tx_dir,
    input  logic              cfg_force_tog,
    input  logic              cfg_int_en,
    input  logic [LEN_W-1:0]  cfg_maxp,
    input  logic              flush,
    input  logic              uf_clr,
    input  logic              ld_wr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_commit,
    output logic              dma_req,
    input  logic              in_tok,
    output logic              tx_go,
    output logic [LEN_W-1:0]  tx_len,
    output logic              tx_data1,
    output logic              tx_nak,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_done,
    input  logic              tx_ack,
    output logic              underrun,
    output logic              irq,
    output logic [1:0]        pkt_count
);
    logic             st_wr_en;
    logic [PTR_W:0]   st_wr_addr;
    logic [PTR_W:0]   st_rd_addr;

    iso_tx_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_iso       (cfg_iso),
        .cfg_dbl       (cfg_dbl),
        .cfg_dma_en    (cfg_dma_en),
        .cfg_dma_mode  (cfg_dma_mode),
        .cfg_tx_dir    (cfg_tx_dir),
        .cfg_force_tog (cfg_force_tog),
        .cfg_int_en    (cfg_int_en),
        .cfg_maxp      (cfg_maxp),
        .flush         (flush),
        .uf_clr        (uf_clr),
        .ld_wr         (ld_wr),
        .ld_commit     (ld_commit),
        .in_tok        (in_tok),
        .rd_en         (rd_en),
        .tx_done       (tx_done),
        .tx_ack        (tx_ack),
        .wr_en         (st_wr_en),
        .wr_addr       (st_wr_addr),
        .rd_addr       (st_rd_addr),
        .dma_req       (dma_req),
        .tx_go         (tx_go),
        .tx_len        (tx_len),
        .tx_data1      (tx_data1),
        .tx_nak        (tx_nak),
        .underrun      (underrun),
        .irq           (irq),
        .pkt_count     (pkt_count)
    );

    iso_tx_store #(.DATA_W(DATA_W), .ADDR_W(PTR_W + 1)) u_store (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_addr (st_wr_addr),
        .wr_data (ld_data),
        .rd_addr (st_rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/iso_tx_pktbuf_chk.sv
// Property checker attached to the packet buffer top.
module iso_tx_pktbuf_chk #(
    parameter  int MAX_BYTES = 64,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_iso,
    input logic             cfg_dbl,
    input logic             cfg_dma_en,
    input logic             cfg_dma_mode,
    input logic             cfg_tx_dir,
    input logic             flush,
    input logic             uf_clr,
    input logic             in_tok,
    input logic             dma_req,
    input logic             tx_go,
    input logic [LEN_W-1:0] tx_len,
    input logic             tx_data1,
    input logic             tx_nak,
    input logic             underrun,
    input logic             irq,
    input logic [1:0]       pkt_count
);
    a_r1_max_two: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_count <= 2'd2);

    a_r1_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dbl && pkt_count <= 2'd1) |=> pkt_count <= 2'd1);

    a_r2_req_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dma_en && cfg_tx_dir && pkt_count == 2'd0) |-> dma_req);

    a_r2_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (cfg_dma_en && cfg_tx_dir));

    a_r5_zlp_on_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> (tx_go && tx_len == '0));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !uf_clr && !flush) |=> underrun);

    a_r5_go_nak_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_go && tx_nak));

    a_r6_dma_mode_err_only: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(cfg_dma_en && cfg_dma_mode)) |-> (tx_go && tx_len == '0));

    a_r7_iso_data0: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_iso |-> !tx_data1);

    a_r8_dir_ignores_tok: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_tx_dir && in_tok) |=> (!tx_go && !tx_nak));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pkt_count == 2'd0 && !underrun));
endmodule

bind iso_tx_pktbuf iso_tx_pktbuf_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_iso      (cfg_iso),
    .cfg_dbl      (cfg_dbl),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_dma_mode (cfg_dma_mode),
    .cfg_tx_dir   (cfg_tx_dir),
    .flush        (flush),
    .uf_clr       (uf_clr),
    .in_tok       (in_tok),
    .dma_req      (dma_req),
    .tx_go        (tx_go),
    .tx_len       (tx_len),
    .tx_data1     (tx_data1),
    .tx_nak       (tx_nak),
    .underrun     (underrun),
    .irq          (irq),
    .pkt_count    (pkt_count)
);

// File: tb/iso_tx_pktbuf_test.sv
module iso_tx_pktbuf_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int MAX_BYTES  = 64;
    localparam int LEN_W      = $clog2(MAX_BYTES + 1);
    localparam int MAXP       = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_iso = 1'b1, cfg_dbl = 1'b0, cfg_dma_en = 1'b0, cfg_dma_mode = 1'b0;
    logic              cfg_tx_dir = 1'b1, cfg_force_tog = 1'b0, cfg_int_en = 1'b1;
    logic [LEN_W-1:0]  cfg_maxp = LEN_W'(MAXP);
    logic              flush = 1'b0, uf_clr = 1'b0;
    logic              ld_wr = 1'b0, ld_commit = 1'b0;
    logic [DATA_W-1:0] ld_data = '0;
    logic              dma_req;
    logic              in_tok = 1'b0;
    logic              tx_go;
    logic [LEN_W-1:0]  tx_len;
    logic              tx_data1, tx_nak;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              tx_done = 1'b0, tx_ack = 1'b0;
    logic              underrun, irq;
    logic [1:0]        pkt_count;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    iso_tx_pktbuf #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cfg_dbl(cfg_dbl),
        .cfg_dma_en(cfg_dma_en), .cfg_dma_mode(cfg_dma_mode), .cfg_tx_dir(cfg_tx_dir),
        .cfg_force_tog(cfg_force_tog), .cfg_int_en(cfg_int_en), .cfg_maxp(cfg_maxp),
        .flush(flush), .uf_clr(uf_clr), .ld_wr(ld_wr), .ld_data(ld_data),
        .ld_commit(ld_commit), .dma_req(dma_req), .in_tok(in_tok), .tx_go(tx_go),
        .tx_len(tx_len), .tx_data1(tx_data1), .tx_nak(tx_nak), .rd_en(rd_en),
        .rd_data(rd_data), .tx_done(tx_done), .tx_ack(tx_ack), .underrun(underrun),
        .irq(irq), .pkt_count(pkt_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    task automatic load_pkt(int n, int base);
        for (int i = 0; i < n; i++) begin
            ld_wr   = 1'b1;
            ld_data = DATA_W'(base + i);
            tick();
        end
        ld_wr     = 1'b0;
        ld_commit = 1'b1;
        tick();
        ld_commit = 1'b0;
    endtask

    // Token, byte read-out, completion report; checks answer, bytes and irq.
    task automatic send(string tag, int exp_len, int base, bit ack, int exp_irq);
        in_tok = 1'b1;
        tick();
        in_tok = 1'b0;
        check({tag, " tx_go"}, int'(tx_go), 1);
        check({tag, " tx_len"}, int'(tx_len), exp_len);
        for (int i = 0; i < exp_len; i++) begin
            check({tag, " R4 byte"}, int'(rd_data), (base + i) & 8'hFF);
            rd_en = 1'b1;
            tick();
            rd_en = 1'b0;
        end
        tx_done = 1'b1;
        tx_ack  = ack;
        tick();
        tx_done = 1'b0;
        tx_ack  = 1'b0;
        check({tag, " R6 irq"}, int'(irq), exp_irq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) tick();
        check("R10 pkt_count", int'(pkt_count), 0);
        check("R10 underrun", int'(underrun), 0);
        check("R10 irq", int'(irq), 0);
        check("R10 tx_go", int'(tx_go), 0);
        check("R10 tx_nak", int'(tx_nak), 0);
        check("R10 tx_data1", int'(tx_data1), 0);
        rst_n = 1'b1;
        tick();
        check("R10 pkt_count after release", int'(pkt_count), 0);

        // R1 R2 R3 R4 sweep over buffering mode and packet length
        cfg_dma_en = 1'b1;
        for (int dbl = 0; dbl < 2; dbl++) begin
            for (int n = 0; n < 6; n++) begin
                int cap;
                int exp_len;
                cfg_dbl = dbl[0];
                cap     = dbl + 1;
                exp_len = (n > MAXP) ? MAXP : n;
                do_flush();
                check("R2 dma_req empty", int'(dma_req), 1);
                load_pkt(n, 8'h10);
                load_pkt(n, 8'h20);
                load_pkt(n, 8'h30);
                check("R1 pkt_count full", int'(pkt_count), cap);
                check("R2 dma_req full", int'(dma_req), 0);
                send("R3 first", exp_len, 8'h10, 1'b0, 1);
                check("R1 count after first", int'(pkt_count), cap - 1);
                if (dbl == 1) send("R4 second", exp_len, 8'h20, 1'b0, 1);
                check("R1 drained", int'(pkt_count), 0);
                check("R5 no underrun", int'(underrun), 0);
                check("R2 dma_req drained", int'(dma_req), 1);
            end
        end

        // R5 underrun, isochronous
        cfg_dbl = 1'b1;
        in_tok = 1'b1;
        tick();
        in_tok = 1'b0;
        check("R5 zlp go", int'(tx_go), 1);
        check("R5 zlp len", int'(tx_len), 0);
        check("R5 underrun set", int'(underrun), 1);
        check("R6 underrun irq", int'(irq), 1);
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        check("R6 no irq on zlp done", int'(irq), 0);
        check("R5 count stays 0", int'(pkt_count), 0);
        repeat (3) tick();
        check("R5 sticky", int'(underrun), 1);
        load_pkt(2, 8'h40);
        send("R5 next pkt", 2, 8'h40, 1'b0, 1);
        check("R5 sticky after pkt", int'(underrun), 1);
        uf_clr = 1'b1;
        tick();
        uf_clr = 1'b0;
        check("R5 cleared", int'(underrun), 0);

        // R6 DMA mode suppresses completion interrupts only
        cfg_dma_mode = 1'b1;
        load_pkt(3, 8'h50);
        send("R6 dma mode", 3, 8'h50, 1'b0, 0);
        in_tok = 1'b1;
        tick();
        in_tok = 1'b0;
        check("R6 dma mode underrun irq", int'(irq), 1);
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        cfg_int_en = 1'b0;
        in_tok = 1'b1;
        tick();
        in_tok = 1'b0;
        check("R6 disabled irq", int'(irq), 0);
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        cfg_dma_mode = 1'b0;
        cfg_int_en = 1'b1;
        do_flush();

        // R5 non-isochronous empty token gets NAK
        cfg_iso = 1'b0;
        in_tok = 1'b1;
        tick();
        in_tok = 1'b0;
        check("R5 nak", int'(tx_nak), 1);
        check("R5 nak no go", int'(tx_go), 0);
        check("R5 nak no underrun", int'(underrun), 0);

        // R7 toggle and retry
        load_pkt(3, 8'h60);
        check("R7 toggle start", int'(tx_data1), 0);
        send("R7 unacked", 3, 8'h60, 1'b0, 0);
        check("R7 kept", int'(pkt_count), 1);
        check("R7 no flip", int'(tx_data1), 0);
        send("R7 resend", 3, 8'h60, 1'b1, 1);
        check("R7 freed", int'(pkt_count), 0);
        check("R7 flipped", int'(tx_data1), 1);
        cfg_force_tog = 1'b1;
        load_pkt(2, 8'h70);
        send("R7 forced", 2, 8'h70, 1'b0, 0);
        check("R7 forced flip", int'(tx_data1), 0);
        check("R7 forced kept", int'(pkt_count), 1);
        cfg_iso = 1'b1;
        send("R7 iso frees", 2, 8'h70, 1'b0, 1);
        check("R7 iso freed", int'(pkt_count), 0);
        check("R7 iso data0", int'(tx_data1), 0);
        cfg_force_tog = 1'b0;

        // R8 direction not transmit
        cfg_tx_dir = 1'b0;
        tick();
        check("R8 dma_req low", int'(dma_req), 0);
        load_pkt(2, 8'h80);
        check("R8 count unchanged", int'(pkt_count), 0);
        in_tok = 1'b1;
        tick();
        in_tok = 1'b0;
        check("R8 no go", int'(tx_go), 0);
        check("R8 no nak", int'(tx_nak), 0);
        check("R8 no underrun", int'(underrun), 0);
        cfg_tx_dir = 1'b1;

        // R9 flush drops committed and partial packets
        in_tok = 1'b1;
        tick();
        in_tok = 1'b0;
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        load_pkt(2, 8'h90);
        ld_wr = 1'b1;
        ld_data = 8'hEE;
        tick();
        ld_wr = 1'b0;
        check("R9 before flush", int'(pkt_count), 1);
        do_flush();
        check("R9 count cleared", int'(pkt_count), 0);
        check("R9 underrun cleared", int'(underrun), 0);
        load_pkt(1, 8'hA0);
        send("R9 fresh", 1, 8'hA0, 1'b0, 1);

        // R3 maxp above storage clamps to MAX_BYTES
        cfg_maxp = LEN_W'(MAX_BYTES + 3);
        load_pkt(MAX_BYTES + 2, 8'h00);
        send("R3 clamp", MAX_BYTES, 8'h00, 1'b0, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule